// File: doc/BRIEF.md
# Masked GPIO port controller

This block is a memory-mapped general-purpose I/O controller for a bank of ports, each up to 16 pins wide, sitting behind a simple single-cycle bus slave. Each pin has its own direction bit that drives the pad's output-enable. Software can change the output register in four ways: write the whole port, write through a protection mask that keeps chosen bits unchanged, set bits by writing ones, or clear bits by writing ones. Reads return the direction register, the mask register, the output register, the synchronized pin levels, or those pin levels with the protected positions forced to zero.

The bus has one select strobe with a write flag, a word address and byte enables. Byte and half-word writes change only the enabled lanes. Each port occupies a 32-byte window. The port index sits in the address bits above bit 4, and the register sits in address bits 4:2. Read data is registered and comes with a one-cycle valid strobe. Pin inputs pass through a two-stage synchronizer. The pull-up-enable flag for each pin comes out of reset set and is not changed afterwards.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction, mask and output bit is 0, pin_oe and pin_out are all zero, bus_rvalid is 0, and every bit of pin_pu_en is 1.
- R2: A write to register offset 0x00 (direction) sets pin_oe for that port from the written bits; pin_oe changes on the clock edge that accepts the write; with no direction write, pin_oe holds.
- R3: A write to offset 0x0C (port) loads the written bits into the output register, and pin_out shows them from the accepting edge on.
- R4: A write to offset 0x10 (set) drives high every output bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to offset 0x14 (clear) drives low every output bit written as 1 and leaves every bit written as 0 unchanged.
- R6: Offset 0x04 holds the mask; a write to offset 0x08 (masked) updates only output bits whose mask bit is 0 and keeps the bits whose mask bit is 1.
- R7: Byte enable bit 0 gates pin bits 7:0 and bit 1 gates pin bits 15:8 in every register; byte enables 3:2 and write data bits 31:16 have no effect.
- R8: Reads return direction at 0x00, mask at 0x04, synchronized pins ANDed with the inverted mask at 0x08, synchronized pins at 0x0C, and the output register at 0x10 and 0x14; bits 31:16 read 0. A pin change is seen by a read accepted two or more edges after the pin change has been registered, and not by an earlier read.
- R9: A read accepted on a clock edge makes bus_rdata valid and bus_rvalid high in the cycle after that edge; bus_rvalid is low after any edge that did not accept a read.
- R10: Offsets 0x18 and 0x1C, and port indices at or beyond the number of ports, read as zero and ignore writes.
- R11: A write to one port changes no register and no pin of any other port.
- R12: pin_out follows the output register whatever the direction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 register, upper bits port |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | NUM_PORTS*PIN_W | Raw pin levels, port p at bits p*PIN_W |
| pin_out | output | NUM_PORTS*PIN_W | Output register values |
| pin_oe | output | NUM_PORTS*PIN_W | Output enables (direction bits) |
| pin_pu_en | output | NUM_PORTS*PIN_W | Pull-up enable flags |

## Verification
Register writes take effect on the edge that accepts them, so pin_out and pin_oe are checked at the falling edge right after the write. Read data is due one edge after the read is accepted. The driver pushes each expected word when it issues the read, and the monitor pops that word at the falling edge where bus_rvalid is high. A pin change needs two synchronizer edges before a read can see it. The bench therefore issues back-to-back reads around a pin change and expects the old level for the first two and the new level for the third.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    OFS_DIR  = 3'd0,
    OFS_MASK = 3'd1,
    OFS_MPIN = 3'd2,
    OFS_PORT = 3'd3,
    OFS_SET  = 3'd4,
    OFS_CLR  = 3'd5
  } reg_ofs_e;

  localparam int PORT_SPAN_BITS = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       ofs,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] lane,
  input  logic [PIN_W-1:0] pin_sync,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] out_q,
  output logic [PIN_W-1:0] rd_word
);
  logic [PIN_W-1:0] mask_q;
  logic [PIN_W-1:0] wbits;
  logic [PIN_W-1:0] free_bits;

  assign wbits     = wdata & lane;
  assign free_bits = lane & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_DIR:  dir_q  <= (dir_q & ~lane) | wbits;
        OFS_MASK: mask_q <= (mask_q & ~lane) | wbits;
        OFS_MPIN: out_q  <= (out_q & ~free_bits) | (wdata & free_bits);
        OFS_PORT: out_q  <= (out_q & ~lane) | wbits;
        OFS_SET:  out_q  <= out_q | wbits;
        OFS_CLR:  out_q  <= out_q & ~wbits;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_DIR:  rd_word = dir_q;
      OFS_MASK: rd_word = mask_q;
      OFS_MPIN: rd_word = pin_sync & ~mask_q;
      OFS_PORT: rd_word = pin_sync;
      OFS_SET:  rd_word = out_q;
      OFS_CLR:  rd_word = out_q;
      default:  rd_word = '0;
    endcase
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ofs == OFS_DIR) |=> $stable(dir_q)); // R2

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_SET) |=>
      ((out_q & $past(wbits)) == $past(wbits)) &&
      ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits)))); // R4

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_CLR) |=>
      ((out_q & $past(wbits)) == '0) &&
      ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits)))); // R5

  AST_MASK_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_MPIN) |=>
      ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q)))); // R6

  AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(out_q)); // R11
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PIN_W     = 16,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W/8-1:0]        bus_be,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NUM_PORTS*PIN_W-1:0] pin_in,
  output logic [NUM_PORTS*PIN_W-1:0] pin_out,
  output logic [NUM_PORTS*PIN_W-1:0] pin_oe,
  output logic [NUM_PORTS*PIN_W-1:0] pin_pu_en
);
  localparam int NPINS  = NUM_PORTS * PIN_W;
  localparam int IDX_W  = ADDR_W - PORT_SPAN_BITS;

  logic [IDX_W-1:0] port_idx;
  logic [2:0]       ofs;
  logic             port_hit;
  logic             ofs_hit;
  logic             hit;
  logic [PIN_W-1:0] lane;
  logic [NPINS-1:0] pin_sync;
  logic [PIN_W-1:0] rd_words [NUM_PORTS];
  logic [PIN_W-1:0] rd_sel;

  assign port_idx = bus_addr[ADDR_W-1:PORT_SPAN_BITS];
  assign ofs      = bus_addr[PORT_SPAN_BITS-1:2];
  assign port_hit = int'(port_idx) < NUM_PORTS;
  assign ofs_hit  = ofs <= 3'(OFS_CLR);
  assign hit      = port_hit && ofs_hit;

  always_comb begin
    for (int b = 0; b < PIN_W; b++) lane[b] = bus_be[b/8];
  end

  gpio_sync #(.W(NPINS)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_en_p;
    assign wr_en_p = bus_sel && bus_wr && hit && (int'(port_idx) == p);

    gpio_port #(.PIN_W(PIN_W)) i_port (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en_p),
      .ofs      (ofs),
      .wdata    (bus_wdata[PIN_W-1:0]),
      .lane     (lane),
      .pin_sync (pin_sync[p*PIN_W +: PIN_W]),
      .dir_q    (pin_oe[p*PIN_W +: PIN_W]),
      .out_q    (pin_out[p*PIN_W +: PIN_W]),
      .rd_word  (rd_words[p])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (int'(port_idx) == p) rd_sel = rd_words[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      pin_pu_en  <= '1;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr)
        bus_rdata <= hit ? {{(DATA_W-PIN_W){1'b0}}, rd_sel} : '0;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_wr)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !hit) |=> (bus_rdata == '0)); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[DATA_W-1:PIN_W] == '0)); // R8
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int NP = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP*PW-1:0] pin_in = '0;
  logic [NP*PW-1:0] pin_out, pin_oe, pin_pu_en;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] exp; string req; } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu_en(pin_pu_en)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] adr(input int port, input int o);
    return {port[3:0], o[2:0], 2'b00};
  endfunction

  // called at a falling edge; returns at the next falling edge with the bus idle
  task automatic bus_write(input int port, input int o, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(port, o); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int port, input int o, input logic [31:0] exp, input string req);
    rd_item_t it;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr(port, o); bus_be = 4'hF;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor: pops expected read data when the design presents it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: unexpected rvalid, actual %0h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(it.req, 128'(bus_rdata), 128'(it.exp));
      end
    end
  end

  function automatic logic [15:0] slc(input logic [NP*PW-1:0] v, input int p);
    return v[p*PW +: PW];
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 128'(pin_oe), 128'(0));
    chk("R1 out", 128'(pin_out), 128'(0));
    chk("R1 pullup", 128'(pin_pu_en), {128{1'b1}});
    chk("R1 rvalid", 128'(bus_rvalid), 128'(0));
    bus_read(0, 0, 32'h0, "R1 dir read");
    bus_read(0, 1, 32'h0, "R1 mask read");
    @(negedge clk);
    chk("R9 rvalid low when idle", 128'(bus_rvalid), 128'(0));

    // R2 direction
    bus_write(2, 0, 32'h0000_00F0, 4'hF);
    chk("R2 oe port2", 128'(slc(pin_oe, 2)), 128'(16'h00F0));
    chk("R11 oe port1", 128'(slc(pin_oe, 1)), 128'(0));
    bus_read(2, 0, 32'h0000_00F0, "R8 dir read");

    // R3 whole-port write, R12 independent of direction
    bus_write(2, 3, 32'h0000_A5C3, 4'hF);
    chk("R3 out port2", 128'(slc(pin_out, 2)), 128'(16'hA5C3));
    chk("R12 out ignores dir", 128'(slc(pin_out, 2) & ~slc(pin_oe, 2)), 128'(16'hA503));
    bus_read(2, 4, 32'h0000_A5C3, "R8 set-offset read");

    // R4 set, R5 clear
    bus_write(2, 4, 32'h0000_0F00, 4'hF);
    chk("R4 set", 128'(slc(pin_out, 2)), 128'(16'hAFC3));
    bus_write(2, 5, 32'h0000_00C1, 4'hF);
    chk("R5 clear", 128'(slc(pin_out, 2)), 128'(16'hAF02));
    bus_read(2, 5, 32'h0000_AF02, "R8 clr-offset read");

    // R6 masked write
    bus_write(2, 1, 32'h0000_FF00, 4'hF);
    bus_read(2, 1, 32'h0000_FF00, "R6 mask read");
    bus_write(2, 2, 32'h0000_1234, 4'hF);
    chk("R6 masked write", 128'(slc(pin_out, 2)), 128'(16'hAF34));

    // R7 byte lanes
    bus_write(2, 3, 32'h0000_5566, 4'b0001);
    chk("R7 low lane only", 128'(slc(pin_out, 2)), 128'(16'hAF66));
    bus_write(2, 4, 32'h0000_5050, 4'b0010);
    chk("R7 high lane set", 128'(slc(pin_out, 2)), 128'(16'hFF66));
    bus_write(2, 0, 32'hFFFF_0000, 4'b1100);
    chk("R7 upper lanes ignored", 128'(slc(pin_oe, 2)), 128'(16'h00F0));

    // R8 pin read through synchronizer
    pin_in[2*PW +: PW] = 16'h3C5A;
    bus_read(2, 3, 32'h0, "R8 pin read too early (1)");
    bus_read(2, 3, 32'h0, "R8 pin read too early (2)");
    bus_read(2, 3, 32'h0000_3C5A, "R8 pin read after sync");
    bus_read(2, 2, 32'h0000_005A, "R8 masked pin read");

    // R10 unmapped
    bus_read(9, 0, 32'h0, "R10 port beyond range");
    bus_read(2, 6, 32'h0, "R10 offset 0x18");
    bus_write(2, 7, 32'hFFFF_FFFF, 4'hF);
    bus_write(9, 3, 32'hFFFF_FFFF, 4'hF);
    chk("R10 write ignored out", 128'(pin_out), 128'(16'hFF66) << (2*PW));
    chk("R10 write ignored oe", 128'(pin_oe), 128'(16'h00F0) << (2*PW));

    // R11 port independence
    bus_write(7, 3, 32'h0000_1111, 4'hF);
    chk("R11 port7 out", 128'(slc(pin_out, 7)), 128'(16'h1111));
    chk("R11 port2 kept", 128'(slc(pin_out, 2)), 128'(16'hFF66));
    bus_read(0, 4, 32'h0, "R11 port0 untouched");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9: missing read data, actual %0d pending expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule